// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim and Complete

The block collects level interrupt lines from a parameterised set of sources and routes them to a small number of target contexts. Each context represents one privilege level of one processor. Every source has a programmable priority. Every context has its own enable bits, a priority threshold, and a single claim/complete register. The context's interrupt output is high whenever a pending, enabled source has a priority strictly above that context's threshold.

Software handles an interrupt in two steps. It reads the claim register and gets the winning source ID, or 0 when nothing qualifies. That read also moves the source from pending to in-service. When handling is finished, software writes the same ID back to the same register, and the source may then be delivered again. Source ID 0 is reserved and means "nothing".

All registers are reached over a plain 32-bit register bus. A write takes effect at the clock edge of the cycle in which the bus is valid. Read data is combinational in that same cycle.

Top module: `irq_router`

## Requirements
- R1: After reset, all priorities, enable bits and thresholds read 0. No source is pending or in service, every `ctx_irq` bit is low, and every claim read returns 0.
- R2: The priority of source n (1..NSRC) sits at byte address 4·n. Only the low PRIO_W bits are stored, and the upper bits read 0. Address 0 (source 0) reads 0. Bus addresses must have bits [1:0] equal to 0 to hit a register.
- R3: The enable word w of context c sits at 0x2000 + 0x80·c + 4·w. Source n is enabled by bit (n mod 32) of word (n div 32). The bit for source 0 and the bits above NSRC always read 0.
- R4: The threshold of context c sits at 0x200000 + 0x1000·c, and its claim/complete register at 0x200000 + 0x1000·c + 4. The threshold keeps PRIO_W bits.
- R5: Source n is driven on `irq_src` bit n-1. A high level sets the pending bit at the next clock edge, provided the source is not in service. Pending stays set after the line falls, until the source is claimed.
- R6: A source qualifies for a context only if it is pending, enabled for that context, and its priority is strictly greater than the context's threshold. A priority of 0 therefore never qualifies.
- R7: `ctx_irq[c]` is high in exactly the cycles in which at least one source qualifies for context c. It follows register state combinationally.
- R8: A claim read returns the qualifying source with the highest priority. Among equal priorities it returns the lowest ID. It returns 0 when none qualifies.
- R9: A claim read that returns a non-zero ID clears that source's pending bit and puts it in service for the reading context. While in service, the source is not pending and qualifies for no context, even if its line stays high.
- R10: Writing the in-service ID to the claim register of the context that claimed it ends service. If the line is still high, the source becomes pending again at the following clock edge.
- R11: A completion write is ignored in any of these cases: the ID is 0, the ID is above NSRC, the source is not in service, or the source was claimed by another context.
- R12: Addresses that map to no register read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NSRC | Level interrupt lines; bit n-1 belongs to source n |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| ctx_irq | output | NCTX | Interrupt request per context |

## Verification
The bench builds the block with NSRC=31, NCTX=2 and PRIO_W=3. With 31 sources, each context has exactly one enable word, and both the reserved bit 0 and the top source bit 31 appear in a single write. Two contexts make it possible to check routing to one context and not the other, and to check that a completion from the wrong context is ignored. Three priority bits are enough to test truncation of an all-ones write, ties, and the strict threshold comparison at both its top and its bottom.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_src,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCTX-1:0]   ctx_irq
);

  localparam int IW = $clog2(NSRC + 1);
  localparam int NW = NSRC / 32 + 1;
  localparam int EW = NW * 32;
  localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam logic [EW-1:0] ONE = 1;
  localparam logic [EW-1:0] EN_MASK = ((ONE << (NSRC + 1)) - ONE) ^ ONE;
  localparam logic [31:0] CTX_BASE = 32'h0020_0000;
  localparam logic [31:0] EN_BASE  = 32'h0000_2000;

  logic [PRIO_W-1:0] prio_q [1:NSRC];
  logic [EW-1:0]     en_q   [NCTX];
  logic [PRIO_W-1:0] thr_q  [NCTX];
  logic [CW-1:0]     own_q  [1:NSRC];
  logic [NSRC:1]     pend_q, busy_q;

  logic [IW-1:0]     best_id [NCTX];
  logic [PRIO_W-1:0] best_p  [NCTX];

  logic [31:0] a, en_off;
  logic        pri_hit, en_hit, ctx_hit, thr_hit, clm_hit;
  int          pidx, ecx, ewd, cidx, widx;
  logic [IW-1:0] clm_id;
  logic        do_claim, do_done;

  assign a      = 32'(bus_addr);
  assign en_off = a - EN_BASE;
  assign pidx   = int'(a[11:2]);
  assign ecx    = int'(en_off[20:7]);
  assign ewd    = int'(en_off[6:2]);
  assign cidx   = int'(a[20:12]);
  assign widx   = int'(bus_wdata[IW-1:0]);

  assign pri_hit = (a[1:0] == 2'b00) && (a < 32'h1000) && (pidx >= 1) && (pidx <= NSRC);
  assign en_hit  = (en_off[1:0] == 2'b00) && (a >= EN_BASE) && (a < CTX_BASE)
                   && (en_off[31:7] < 25'(NCTX)) && (ewd < NW);
  assign ctx_hit = (a >= CTX_BASE) && (a < CTX_BASE + 32'(NCTX) * 32'h1000);
  assign thr_hit = ctx_hit && (a[11:0] == 12'h000);
  assign clm_hit = ctx_hit && (a[11:0] == 12'h004);

  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      best_id[c] = '0;
      best_p[c]  = '0;
      for (int k = 1; k <= NSRC; k++) begin
        if (pend_q[k] && en_q[c][k] && (prio_q[k] > thr_q[c]) && (prio_q[k] > best_p[c])) begin
          best_id[c] = IW'(k);
          best_p[c]  = prio_q[k];
        end
      end
      ctx_irq[c] = (best_id[c] != '0);
    end
  end

  always_comb begin
    clm_id = '0;
    if (clm_hit) clm_id = best_id[cidx];
  end

  assign do_claim = bus_valid && !bus_write && clm_hit && (clm_id != '0);

  always_comb begin
    do_done = 1'b0;
    if (bus_valid && bus_write && clm_hit && (bus_wdata >= 32'd1) && (bus_wdata <= 32'(NSRC)))
      do_done = busy_q[widx] && (own_q[widx] == CW'(cidx));
  end

  always_comb begin
    bus_rdata = '0;
    if (pri_hit)      bus_rdata = 32'(prio_q[pidx]);
    else if (en_hit)  bus_rdata = en_q[ecx][ewd*32 +: 32];
    else if (thr_hit) bus_rdata = 32'(thr_q[cidx]);
    else if (clm_hit) bus_rdata = 32'(clm_id);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k <= NSRC; k++) begin
        prio_q[k] <= '0;
        own_q[k]  <= '0;
      end
      for (int c = 0; c < NCTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
      pend_q <= '0;
      busy_q <= '0;
    end else begin
      if (bus_valid && bus_write) begin
        if (pri_hit) prio_q[pidx] <= bus_wdata[PRIO_W-1:0];
        if (en_hit)  en_q[ecx][ewd*32 +: 32] <= bus_wdata & EN_MASK[ewd*32 +: 32];
        if (thr_hit) thr_q[cidx] <= bus_wdata[PRIO_W-1:0];
      end
      for (int k = 1; k <= NSRC; k++) begin
        if (do_claim && (clm_id == IW'(k))) begin
          pend_q[k] <= 1'b0;
          busy_q[k] <= 1'b1;
          own_q[k]  <= CW'(cidx);
        end else if (do_done && (widx == k)) begin
          busy_q[k] <= 1'b0;
        end else if (irq_src[k-1] && !busy_q[k]) begin
          pend_q[k] <= 1'b1;
        end
      end
    end
  end

endmodule

module irq_router_chk #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NCTX-1:0]   ctx_irq,
  input logic [NSRC:1]     pend_q,
  input logic [NSRC:1]     busy_q
);

  logic [31:0] ca;
  logic        claim_acc;
  assign ca = 32'(bus_addr);
  assign claim_acc = bus_valid && (ca >= 32'h0020_0000)
                     && (ca < 32'h0020_0000 + 32'(NCTX) * 32'h1000) && (ca[11:0] == 12'h004);

  // R9
  no_pend_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & busy_q) == '0);

  // R9
  claim_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_acc && !bus_write && (bus_rdata != 32'd0))
    |=> ($countones(busy_q) == $past($countones(busy_q)) + 1));

  // R7
  idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (ctx_irq == '0));

  // R11
  zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_acc && bus_write && (bus_wdata == 32'd0)) |=> (busy_q == $past(busy_q)));

endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC), .NCTX(NCTX), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ctx_irq(ctx_irq), .pend_q(pend_q), .busy_q(busy_q)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
  localparam int NSRC = 31;
  localparam int NCTX = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] irq_src = '0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [21:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCTX-1:0] ctx_irq;

  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  irq_router #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3), .ADDR_W(22)) u_irq_router (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ctx_irq(ctx_irq)
  );

  localparam logic [21:0] CLM0 = 22'h200004, CLM1 = 22'h201004;
  localparam logic [21:0] THR0 = 22'h200000, THR1 = 22'h201000;
  localparam logic [21:0] EN0  = 22'h002000, EN1  = 22'h002080;

  // {prio of source 3, prio of source 5, threshold ctx0, expected claim}
  localparam logic [13:0] VEC [8] = '{
    {3'd2, 3'd5, 3'd0, 5'd5}, {3'd5, 3'd2, 3'd0, 5'd3},
    {3'd4, 3'd4, 3'd0, 5'd3}, {3'd4, 3'd4, 3'd4, 5'd0},
    {3'd4, 3'd6, 3'd4, 5'd5}, {3'd0, 3'd0, 3'd0, 5'd0},
    {3'd1, 3'd0, 3'd0, 5'd3}, {3'd7, 3'd7, 3'd6, 5'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [21:0] ad, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = ad; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [21:0] ad, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = ad;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_up;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_up();
    end
  end

  initial begin
    logic [31:0] d;
    logic [2:0] pa, pb, th;
    logic [4:0] ex;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(1);

    chk("R1 irq", 32'(ctx_irq), 0);
    rd(22'h000004, d); chk("R1 prio", d, 0);
    rd(EN0, d);        chk("R1 enable", d, 0);
    rd(THR0, d);       chk("R1 threshold", d, 0);
    rd(CLM0, d);       chk("R1 claim", d, 0);

    wr(22'h00000C, 32'hFFFF_FFFF);
    rd(22'h00000C, d); chk("R2 prio truncation", d, 7);
    rd(22'h000000, d); chk("R2 source0", d, 0);
    wr(EN1, 32'hFFFF_FFFF);
    rd(EN1, d);        chk("R3 reserved bit0", d, 32'hFFFF_FFFE);
    wr(EN1, 0);
    wr(THR1, 5);
    rd(THR1, d);       chk("R4 threshold ctx1", d, 5);
    wr(THR1, 0);
    wr(22'h001000, 32'h5);
    rd(22'h001000, d); chk("R12 unmapped read", d, 0);
    rd(22'h202000, d); chk("R12 no such context", d, 0);
    rd(22'h00000C, d); chk("R12 write ignored", d, 7);

    // table: sources 3 and 5 held high, enabled for context 0 only
    wr(EN0, 32'h28);
    irq_src[2] = 1'b1; irq_src[4] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      {pa, pb, th, ex} = VEC[i];
      wr(22'h00000C, 32'(pa));
      wr(22'h000014, 32'(pb));
      wr(THR0, 32'(th));
      settle(1);
      chk($sformatf("R7 vec%0d irq", i), 32'(ctx_irq[0]), 32'(ex != 0));
      chk($sformatf("R6 vec%0d ctx1 idle", i), 32'(ctx_irq[1]), 0);
      rd(CLM0, d);
      chk($sformatf("R8 vec%0d claim", i), d, 32'(ex));
      if (d != 0) wr(CLM0, d);
    end
    irq_src = '0;
    wr(EN0, 0);
    wr(THR0, 0);

    // directed: source 9
    wr(EN0, 32'h200);
    wr(22'h000024, 3);
    @(negedge clk); irq_src[8] = 1'b1;
    @(negedge clk); irq_src[8] = 1'b0;
    settle(2);
    chk("R5 latched pending", 32'(ctx_irq[0]), 1);
    chk("R6 not enabled ctx1", 32'(ctx_irq[1]), 0);
    rd(CLM0, d); chk("R8 claim src9", d, 9);
    settle(1);
    chk("R9 irq drops after claim", 32'(ctx_irq[0]), 0);
    irq_src[8] = 1'b1;
    settle(3);
    chk("R9 held off while high", 32'(ctx_irq[0]), 0);
    rd(CLM0, d); chk("R9 second claim empty", d, 0);
    wr(CLM1, 9);  settle(2); chk("R11 wrong context", 32'(ctx_irq[0]), 0);
    wr(CLM0, 0);  settle(2); chk("R11 id zero", 32'(ctx_irq[0]), 0);
    wr(CLM0, 20); settle(2); chk("R11 not in service", 32'(ctx_irq[0]), 0);
    wr(CLM0, 40); settle(2); chk("R11 out of range", 32'(ctx_irq[0]), 0);
    wr(CLM0, 9);  settle(2); chk("R10 redelivered", 32'(ctx_irq[0]), 1);

    wr(THR0, 3); settle(1); chk("R6 equal to threshold", 32'(ctx_irq[0]), 0);
    wr(THR0, 2); settle(1); chk("R6 above threshold", 32'(ctx_irq[0]), 1);
    wr(THR0, 0);
    wr(22'h000024, 0); settle(1); chk("R6 priority zero", 32'(ctx_irq[0]), 0);
    wr(22'h000024, 3);

    wr(EN1, 32'h200); settle(1); chk("R7 ctx1 raised", 32'(ctx_irq[1]), 1);
    rd(CLM1, d); chk("R8 claim via ctx1", d, 9);
    settle(1);
    chk("R9 ctx0 cleared by ctx1 claim", 32'(ctx_irq[0]), 0);
    chk("R9 ctx1 cleared", 32'(ctx_irq[1]), 0);
    wr(CLM0, 9); settle(2); chk("R11 foreign completion", 32'(ctx_irq), 0);
    wr(CLM1, 9); settle(2); chk("R10 both contexts again", 32'(ctx_irq), 3);

    done = 1'b1;
    finish_up();
  end
endmodule